// File: doc/BRIEF.md
# Shared Linked-List Flit Buffer

This block holds flits for several virtual channels in a single pool of storage cells. Each virtual channel keeps its own first-in first-out queue as a chain of cells. Every cell carries a link to the next cell of its queue. Cells that hold nothing are chained on a separate free chain. A write names a channel and offers a flit. The block answers in the same cycle whether the flit was taken. A read names a channel and pops the oldest flit of that queue, and the freed cell goes back to the free chain.

An admission stage stops one busy channel from taking the whole pool. The sliding policy always lets a channel hold a small reserved number of cells. Beyond that reserve, a channel may grow only while its count stays under a fraction of the free space plus the reserve. The fraction is a power of two, so it is applied as a right shift of the free count. The simple policy grants a cell to an empty channel, and to any other channel only while more cells are free than there are empty channels. A parameter selects the policy. The block reports the occupancy of each channel on its outputs.

Top module: `vc_cell_pool`

## Requirements
- R1: After reset every channel reports occupancy 0 and all DEPTH cells are free.
- R2: A read of channel v returns the flits accepted for v in the order they were accepted. The flit is on rd_data in the same cycle, with rd_ok high.
- R3: An accepted write raises the occupancy of its channel by one at the next clock edge. A rejected write changes no occupancy and no queue content.
- R4: wr_accept is combinational in the cycle of the request. It is never high while wr_valid is low. It is never high when the free count (DEPTH minus the sum of all occupancies) is zero.
- R5: With POLICY=0 a write to channel v is accepted when free is nonzero and either occ[v] < RSV or occ[v] < (free >> FRAC_SHIFT) + RSV. The rule uses the values at the start of the cycle, before any same-cycle read.
- R6: With POLICY=1 a write to channel v is accepted when free is nonzero and either occ[v] is 0 or free is greater than the number of channels whose occupancy is 0.
- R7: A read of a channel with occupancy 0 gives rd_ok low and rd_data 0, and changes nothing.
- R8: A read and a write in the same cycle both take effect, to the same channel or to different ones. This includes a channel that holds exactly one flit. Each occupancy changes by (accepted write) minus (read).
- R9: Cells freed by reads are reused. After any traffic has been drained, the full pool of DEPTH cells can be allocated again.
- R10: Traffic on one channel never changes the occupancy or the flit order of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_vc | input | VC_W | Channel of the write |
| wr_data | input | DATA_W | Flit to store |
| wr_accept | output | 1 | Write taken this cycle |
| rd_valid | input | 1 | Read request |
| rd_vc | input | VC_W | Channel to pop |
| rd_data | output | DATA_W | Head flit of rd_vc, 0 when rd_ok is low |
| rd_ok | output | 1 | Read performed this cycle |
| occ | output | NUM_VC*CNT_W | Occupancy per channel, channel v at bits [v*CNT_W +: CNT_W] |

## Verification
The hardest state to reach is an empty free chain while some channel is still empty, because both admission policies hold the last cells back for empty channels. The stimulus fills one channel until the simple policy stops it, then places one flit in each remaining channel, then offers more writes. A second hard case is a read and a write to a channel that holds exactly one flit: the head, the tail and the free chain all change in that one edge. A directed sequence builds that case, and a long random phase with mixed reads and writes repeats it and recycles every cell many times before a final refill.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
   localparam int POL_SLIDING = 0;
   localparam int POL_SIMPLE  = 1;

   function automatic int ceil_log2(input int n);
      int r;
      r = 0;
      while ((1 << r) < n) r++;
      return (r < 1) ? 1 : r;
   endfunction
endpackage

// File: rtl/vcp_admit.sv
module vcp_admit
   import vcp_pkg::*;
#(
   parameter int NUM_VC     = 4,
   parameter int CNT_W      = 5,
   parameter int RSV        = 2,
   parameter int FRAC_SHIFT = 1,
   parameter int POLICY     = POL_SLIDING
) (
   input  logic [NUM_VC-1:0][CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0]             free_i,
   input  logic                         req_i,
   input  logic [ceil_log2(NUM_VC)-1:0] vc_i,
   output logic                         grant_o
);
   localparam int VC_W = ceil_log2(NUM_VC);

   logic [CNT_W-1:0] own_cnt;
   logic             rule_ok;

   assign own_cnt = cnt_i[vc_i];

   generate
      if (POLICY == POL_SLIDING) begin : g_sliding
         int limit;
         always_comb begin
            limit   = int'(free_i >> FRAC_SHIFT) + RSV;
            rule_ok = (int'(own_cnt) < RSV) || (int'(own_cnt) < limit);
         end
      end else begin : g_simple
         int empties;
         always_comb begin
            empties = 0;
            for (int v = 0; v < NUM_VC; v++)
               if (cnt_i[v] == '0) empties++;
            rule_ok = (own_cnt == '0) || (int'(free_i) > empties);
         end
      end
   endgenerate

   assign grant_o = req_i && (free_i != '0) && rule_ok;
endmodule

// File: rtl/vcp_cell_store.sv
module vcp_cell_store #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4,
   parameter int PTR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dat_we,
   input  logic [ADDR_W-1:0] dat_waddr,
   input  logic [DATA_W-1:0] dat_wdata,
   input  logic [ADDR_W-1:0] dat_raddr,
   output logic [DATA_W-1:0] dat_rdata,
   input  logic              lnk_a_we,
   input  logic [ADDR_W-1:0] lnk_a_addr,
   input  logic [PTR_W-1:0]  lnk_a_val,
   input  logic              lnk_b_we,
   input  logic [ADDR_W-1:0] lnk_b_addr,
   input  logic [PTR_W-1:0]  lnk_b_val,
   input  logic [ADDR_W-1:0] lnk_r0_addr,
   output logic [PTR_W-1:0]  lnk_r0,
   input  logic [ADDR_W-1:0] lnk_r1_addr,
   output logic [PTR_W-1:0]  lnk_r1
);
   localparam logic [PTR_W-1:0] NIL = {1'b1, {(PTR_W-1){1'b0}}};

   logic [DATA_W-1:0] cell_q [DEPTH];
   logic [PTR_W-1:0]  next_q [DEPTH];

   always_ff @(posedge clk)
      if (dat_we) cell_q[dat_waddr] <= dat_wdata;

   // link array: after reset all cells form one chain 0 -> 1 -> ... -> NIL
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            next_q[i] <= (i == DEPTH - 1) ? NIL : PTR_W'(i + 1);
      end else begin
         if (lnk_a_we) next_q[lnk_a_addr] <= lnk_a_val;
         if (lnk_b_we) next_q[lnk_b_addr] <= lnk_b_val;
      end
   end

   assign dat_rdata = cell_q[dat_raddr];
   assign lnk_r0    = next_q[lnk_r0_addr];
   assign lnk_r1    = next_q[lnk_r1_addr];
endmodule

// File: rtl/vc_cell_pool.sv
module vc_cell_pool
   import vcp_pkg::*;
#(
   parameter int NUM_VC     = 4,
   parameter int DEPTH      = 16,
   parameter int DATA_W     = 16,
   parameter int RSV        = 2,
   parameter int FRAC_SHIFT = 1,
   parameter int POLICY     = POL_SLIDING,
   localparam int VC_W      = ceil_log2(NUM_VC),
   localparam int CNT_W     = ceil_log2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_valid,
   input  logic [VC_W-1:0]         wr_vc,
   input  logic [DATA_W-1:0]       wr_data,
   output logic                    wr_accept,
   input  logic                    rd_valid,
   input  logic [VC_W-1:0]         rd_vc,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    rd_ok,
   output logic [NUM_VC*CNT_W-1:0] occ
);
   localparam int ADDR_W = ceil_log2(DEPTH);
   localparam int PTR_W  = ADDR_W + 1;
   localparam logic [PTR_W-1:0] NIL = {1'b1, {(PTR_W-1){1'b0}}};

   generate
      if (NUM_VC < 2 || (1 << VC_W) != NUM_VC) begin : g_bad_vc
         $error("NUM_VC must be a power of two, at least 2");
      end
      if (DEPTH < NUM_VC || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least NUM_VC");
      end
      if (RSV < 1 || RSV * NUM_VC > DEPTH) begin : g_bad_rsv
         $error("RSV must be at least 1 and fit NUM_VC times in DEPTH");
      end
      if (FRAC_SHIFT < 0 || FRAC_SHIFT > CNT_W) begin : g_bad_shift
         $error("FRAC_SHIFT out of range");
      end
      if (POLICY != POL_SLIDING && POLICY != POL_SIMPLE) begin : g_bad_pol
         $error("POLICY must be 0 or 1");
      end
   endgenerate

   // per-channel queue state and the free chain
   logic [PTR_W-1:0]             head_q [NUM_VC];
   logic [PTR_W-1:0]             tail_q [NUM_VC];
   logic [NUM_VC-1:0][CNT_W-1:0] cnt_q;
   logic [PTR_W-1:0]             fhead_q;
   logic [CNT_W-1:0]             fcnt_q;

   logic              do_wr, do_rd;
   logic [PTR_W-1:0]  pop_ptr, wr_tail;
   logic [ADDR_W-1:0] alloc_a, pop_a;
   logic [PTR_W-1:0]  pop_next, free_next;
   logic [DATA_W-1:0] cell_out;
   logic              rd_cnt_one, wr_cnt_zero, same_vc;
   logic              link_tail;

   vcp_admit #(
      .NUM_VC(NUM_VC), .CNT_W(CNT_W), .RSV(RSV),
      .FRAC_SHIFT(FRAC_SHIFT), .POLICY(POLICY)
   ) u_admit (
      .cnt_i(cnt_q), .free_i(fcnt_q), .req_i(wr_valid),
      .vc_i(wr_vc), .grant_o(do_wr)
   );

   assign do_rd       = rd_valid && (cnt_q[rd_vc] != '0);
   assign pop_ptr     = head_q[rd_vc];
   assign wr_tail     = tail_q[wr_vc];
   assign alloc_a     = fhead_q[ADDR_W-1:0];
   assign pop_a       = pop_ptr[ADDR_W-1:0];
   assign rd_cnt_one  = (cnt_q[rd_vc] == CNT_W'(1));
   assign wr_cnt_zero = (cnt_q[wr_vc] == '0);
   assign same_vc     = (rd_vc == wr_vc);
   // append behind the old tail unless the queue is, or is about to be, empty
   assign link_tail   = do_wr && !wr_cnt_zero && !(do_rd && same_vc && rd_cnt_one);

   vcp_cell_store #(
      .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .dat_we(do_wr), .dat_waddr(alloc_a), .dat_wdata(wr_data),
      .dat_raddr(pop_a), .dat_rdata(cell_out),
      .lnk_a_we(link_tail), .lnk_a_addr(wr_tail[ADDR_W-1:0]), .lnk_a_val(fhead_q),
      .lnk_b_we(do_rd), .lnk_b_addr(pop_a),
      .lnk_b_val(do_wr ? free_next : fhead_q),
      .lnk_r0_addr(pop_a), .lnk_r0(pop_next),
      .lnk_r1_addr(alloc_a), .lnk_r1(free_next)
   );

   // free chain: an allocation takes the head; a released cell becomes the new head
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fhead_q <= '0;
         fcnt_q  <= CNT_W'(DEPTH);
      end else begin
         if (do_rd)      fhead_q <= pop_ptr;
         else if (do_wr) fhead_q <= free_next;
         fcnt_q <= fcnt_q + CNT_W'(do_rd) - CNT_W'(do_wr);
      end
   end

   generate
      for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
         logic hit_w, hit_r, one;
         assign hit_w = do_wr && (wr_vc == VC_W'(v));
         assign hit_r = do_rd && (rd_vc == VC_W'(v));
         assign one   = (cnt_q[v] == CNT_W'(1));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               head_q[v] <= NIL;
               tail_q[v] <= NIL;
               cnt_q[v]  <= '0;
            end else begin
               cnt_q[v] <= cnt_q[v] + CNT_W'(hit_w) - CNT_W'(hit_r);
               if (hit_r) begin
                  if (one) head_q[v] <= hit_w ? fhead_q : NIL;
                  else     head_q[v] <= pop_next;
               end else if (hit_w && cnt_q[v] == '0) begin
                  head_q[v] <= fhead_q;
               end
               if (hit_w)              tail_q[v] <= fhead_q;
               else if (hit_r && one)  tail_q[v] <= NIL;
            end
         end
      end
   endgenerate

   assign wr_accept = do_wr;
   assign rd_ok     = do_rd;
   assign rd_data   = do_rd ? cell_out : '0;
   assign occ       = cnt_q;
endmodule

// File: rtl/vcp_checks.sv
module vcp_checks #(
   parameter int NUM_VC     = 4,
   parameter int DEPTH      = 16,
   parameter int RSV        = 2,
   parameter int FRAC_SHIFT = 1,
   parameter int POLICY     = 0,
   parameter int VC_W       = 2,
   parameter int CNT_W      = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_valid,
   input logic [VC_W-1:0]         wr_vc,
   input logic                    wr_accept,
   input logic                    rd_valid,
   input logic [VC_W-1:0]         rd_vc,
   input logic                    rd_ok,
   input logic [NUM_VC*CNT_W-1:0] occ
);
   int total, wr_occ, rd_occ, free_n;

   always_comb begin
      total = 0;
      for (int v = 0; v < NUM_VC; v++) total += int'(occ[v*CNT_W +: CNT_W]);
      free_n = DEPTH - total;
      wr_occ = int'(occ[wr_vc*CNT_W +: CNT_W]);
      rd_occ = int'(occ[rd_vc*CNT_W +: CNT_W]);
   end

   a_r4_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |-> !wr_accept);

   a_r4_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (total == DEPTH) |-> !wr_accept);

   a_r7_no_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_occ == 0) |-> !rd_ok);

   a_r7_read_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> !rd_ok);

   a_r8_total_conserved: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> total == $past(total) + int'($past(wr_accept)) - int'($past(rd_ok)));

   a_r3_write_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept && !(rd_ok && rd_vc == wr_vc)) |=>
         int'(occ[$past(wr_vc)*CNT_W +: CNT_W]) == $past(wr_occ) + 1);

   a_r9_never_over: assert property (@(posedge clk) disable iff (!rst_n)
      total <= DEPTH);

   generate
      if (POLICY == 0) begin : g_sl
         a_r5_limit: assert property (@(posedge clk) disable iff (!rst_n)
            wr_accept |-> (wr_occ < RSV) || (wr_occ < (free_n >> FRAC_SHIFT) + RSV));
      end else begin : g_si
         int empt;
         always_comb begin
            empt = 0;
            for (int v = 0; v < NUM_VC; v++)
               if (occ[v*CNT_W +: CNT_W] == '0) empt++;
         end
         a_r6_limit: assert property (@(posedge clk) disable iff (!rst_n)
            wr_accept |-> (wr_occ == 0) || (free_n > empt));
      end
   endgenerate
endmodule

bind vc_cell_pool vcp_checks #(
   .NUM_VC(NUM_VC), .DEPTH(DEPTH), .RSV(RSV), .FRAC_SHIFT(FRAC_SHIFT),
   .POLICY(POLICY), .VC_W(VC_W), .CNT_W(CNT_W)
) u_checks (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_vc(wr_vc),
   .wr_accept(wr_accept), .rd_valid(rd_valid), .rd_vc(rd_vc),
   .rd_ok(rd_ok), .occ(occ)
);

// File: tb/tb_vc_cell_pool.sv
module tb_vc_cell_pool;
   localparam int NV = 4, DP = 16, DW = 16, CW = 5;
   localparam int RS [2] = '{2, 1};
   localparam int SH [2] = '{1, 0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wv = 1'b0, rv = 1'b0;
   logic [1:0] wvc = '0, rvc = '0;
   logic [DW-1:0] wd = '0;
   logic acc [2], rok [2];
   logic [DW-1:0] rdat [2];
   logic [NV*CW-1:0] occf [2];

   int vectors = 0, miscompares = 0;
   logic [DW-1:0] mq [2][NV][$];
   logic [DW-1:0] seq_no = 16'h0100;

   always #4 clk = ~clk;

   vc_cell_pool #(.NUM_VC(NV), .DEPTH(DP), .DATA_W(DW), .RSV(2), .FRAC_SHIFT(1), .POLICY(0)) dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_vc(wvc), .wr_data(wd), .wr_accept(acc[0]),
      .rd_valid(rv), .rd_vc(rvc), .rd_data(rdat[0]), .rd_ok(rok[0]), .occ(occf[0]));

   vc_cell_pool #(.NUM_VC(NV), .DEPTH(DP), .DATA_W(DW), .RSV(1), .FRAC_SHIFT(0), .POLICY(1)) dut_simple (
      .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_vc(wvc), .wr_data(wd), .wr_accept(acc[1]),
      .rd_valid(rv), .rd_vc(rvc), .rd_data(rdat[1]), .rd_ok(rok[1]), .occ(occf[1]));

   task automatic cmp(input string req, input int act, input int exp, input string what);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare one instance against the behavioural model, then advance the model
   task automatic check_one(input int k, input string tag);
      int tot, fr, own, emp;
      bit ea, er;
      string atag;
      tot = 0; emp = 0;
      for (int v = 0; v < NV; v++) begin
         tot += mq[k][v].size();
         if (mq[k][v].size() == 0) emp++;
         cmp(tag, int'(occf[k][v*CW +: CW]), mq[k][v].size(), $sformatf("inst%0d occ[%0d]", k, v));
      end
      fr  = DP - tot;
      own = mq[k][wvc].size();
      if (k == 0) ea = (own < RS[0]) || (own < (fr >> SH[0]) + RS[0]);
      else        ea = (own == 0) || (fr > emp);
      ea = ea && wv && (fr > 0);
      atag = (fr == 0) ? "R4" : ((k == 0) ? "R5" : "R6");
      cmp(atag, int'(acc[k]), int'(ea), $sformatf("inst%0d wr_accept", k));
      er = rv && (mq[k][rvc].size() > 0);
      cmp((er ? tag : "R7"), int'(rok[k]), int'(er), $sformatf("inst%0d rd_ok", k));
      cmp((er ? "R2" : "R7"), int'(rdat[k]), er ? int'(mq[k][rvc][0]) : 0,
          $sformatf("inst%0d rd_data", k));
      if (er) void'(mq[k][rvc].pop_front());
      if (ea) mq[k][wvc].push_back(wd);
   endtask

   task automatic step(input bit w, input int wc, input bit r, input int rc, input string tag);
      @(negedge clk);
      wv = w; wvc = 2'(wc); rv = r; rvc = 2'(rc);
      seq_no = seq_no + 16'd1;
      wd = seq_no;
      #1;
      check_one(0, tag);
      check_one(1, tag);
   endtask

   task automatic drain(input string tag);
      for (int v = 0; v < NV; v++)
         for (int i = 0; i <= DP; i++) step(1'b0, 0, 1'b1, v, tag);
   endtask

   initial begin
      #(8 * 200000);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, all idle
      step(1'b0, 0, 1'b0, 0, "R1");
      // R3, R10: a few flits on two channels
      for (int i = 0; i < 3; i++) step(1'b1, 1, 1'b0, 0, "R3");
      for (int i = 0; i < 2; i++) step(1'b1, 2, 1'b0, 0, "R10");
      // R5: push one channel past its sliding limit, rejects leave state alone (R3)
      for (int i = 0; i < 14; i++) step(1'b1, 0, 1'b0, 0, "R3");
      // R2: pop in order
      for (int i = 0; i < 14; i++) step(1'b0, 0, 1'b1, 0, "R2");
      // R7: read an empty channel
      for (int i = 0; i < 3; i++) step(1'b0, 0, 1'b1, 3, "R7");
      // R8: single-flit channel, read and write at once
      step(1'b0, 0, 1'b1, 2, "R8");
      for (int i = 0; i < 4; i++) step(1'b1, 2, 1'b1, 2, "R8");
      step(1'b1, 1, 1'b1, 2, "R8");
      drain("R10");
      // R4, R6: fill one channel until held back, then empty channels take the rest
      for (int i = 0; i < 20; i++) step(1'b1, 0, 1'b0, 0, "R6");
      for (int v = 1; v < NV; v++) for (int i = 0; i < 6; i++) step(1'b1, v, 1'b0, 0, "R6");
      for (int i = 0; i < 4; i++) step(1'b1, i, 1'b0, 0, "R4");
      for (int i = 0; i < 4; i++) step(1'b1, i, 1'b1, (i + 1) % NV, "R8");
      drain("R9");
      // R9: long random mix recycles cells
      for (int i = 0; i < 4000; i++)
         step(1'($urandom_range(0, 2) != 0), int'($urandom_range(0, NV - 1)),
              1'($urandom_range(0, 1)), int'($urandom_range(0, NV - 1)), "R9");
      drain("R9");
      // R9: whole pool available again
      for (int i = 0; i < 20; i++) step(1'b1, 3, 1'b0, 0, "R9");
      for (int v = 0; v < 3; v++) for (int i = 0; i < 6; i++) step(1'b1, v, 1'b0, 0, "R9");
      step(1'b0, 0, 1'b0, 0, "R9");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule